// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key-Protected Restart

This block supervises firmware by counting ticks of a slow watchdog clock. Three 4-bit period codes shape a three-stage window. A wait period catches a restart that arrives too early. An interrupt period raises a timeout flag. A reset period then starts, and when it runs out a one-cycle reset request goes out. Firmware restarts the count by writing two key bytes in a row to a clear register. A second pair of key bytes locks and unlocks the control register.

The block sits on a simple single-cycle 32-bit register bus. The bus carries a write strobe, a word index and write data, and read data is combinational. The watchdog clock arrives as a one-cycle `tick` enable in the bus clock domain. The parameter `EXP_SHIFT` lowers every period exponent by the same amount, so short simulations can reach every stage.

Top module: `wdog_window`

## Requirements
- R1: After reset the control, flag and enable registers read zero, the lock is open, and `irq` and `rst_req` are low.
- R2: The counter advances only on a `tick` cycle while control bit 8 (timer on) and bit 9 (clock on) are both set. Setting both bits when they were not both set restarts the count from zero.
- R3: A period code n lasts 2^(31-EXP_SHIFT-n) ticks. Control [3:0] holds the interrupt code, [7:4] the reset code and [15:12] the wait code. Flag bit 0 sets on the tick that completes the interrupt period.
- R4: The reset period starts when the timeout flag sets. When it completes, flag bit 2 sets and the counter halts. `rst_req` pulses high for one cycle only if enable bit 2 is set.
- R5: Writing 0xA5 and then 0x5A (low byte) to the clear register (index 1) on back-to-back writes restarts the interrupt period from zero. This also abandons a running reset period.
- R6: A lone 0x5A, or any other value written to the clear register between 0xA5 and 0x5A, discards the partial sequence, and the count is not restarted.
- R7: A valid key sequence that completes while the interrupt stage has counted fewer ticks than the wait period sets flag bit 1.
- R8: Flags (index 2) are write-one-to-clear. Writing 0 to a flag bit leaves it unchanged.
- R9: `irq` is high whenever a flag bit and the matching enable bit (index 3, bits [2:0]) are both set.
- R10: Writing 0x24 to the lock register (index 5) makes control writes ineffective. 0x42 reopens them, and other values leave the lock unchanged. The lock register reads back 1 when locked.
- R11: Control (index 0) reads back its fields at the positions of R3 together with bits 8 and 9. The clear register, index 4 and indices 6 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle watchdog clock enable |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `reg_idx` |
| irq | output | 1 | Interrupt: any enabled flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `EXP_SHIFT` set to 12. Codes 12 to 15 then last 128, 64, 32 and 16 ticks, so timeout, reset expiry and the early-clear window each occur within a few hundred cycles. The period codes are drawn at random from that range with a fixed seed. Directed cases cover tick gating, broken key sequences, locking and flag clearing.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int EXP_SHIFT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        rst_req
);

  localparam int MAXE = 31 - EXP_SHIFT;
  localparam int CW   = MAXE + 1;
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_CLR  = 3'd1;
  localparam logic [2:0] IDX_FLG  = 3'd2;
  localparam logic [2:0] IDX_EN   = 3'd3;
  localparam logic [2:0] IDX_LOCK = 3'd5;
  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;
  localparam logic [7:0] KEY_LOCK = 8'h24;
  localparam logic [7:0] KEY_OPEN = 8'h42;

  typedef enum logic [1:0] {ST_INT, ST_RST, ST_DONE} stage_t;

  function automatic logic [CW-1:0] span(input logic [3:0] code);
    span = '0;
    span[MAXE - int'(code)] = 1'b1;
  endfunction

  logic [3:0]    int_code, rst_code, wait_code;
  logic          tmr_on, clk_on, locked, armed;
  logic [2:0]    flg, en_q;
  logic [CW-1:0] cnt;
  stage_t        stage;

  logic wr_ctrl, wr_clr, wr_flg, wr_en_reg, wr_lock;
  logic run, run_nx, start, key_fire, restart, step;
  logic int_hit, rst_hit, early;
  logic [CW-1:0] cnt_nx;
  logic unused_bits;

  assign unused_bits = ^{wdata[31:16], wdata[11:10]};

  assign wr_ctrl   = wr_en && reg_idx == IDX_CTRL && !locked;
  assign wr_clr    = wr_en && reg_idx == IDX_CLR;
  assign wr_flg    = wr_en && reg_idx == IDX_FLG;
  assign wr_en_reg = wr_en && reg_idx == IDX_EN;
  assign wr_lock   = wr_en && reg_idx == IDX_LOCK;

  assign run      = tmr_on & clk_on;
  assign run_nx   = wr_ctrl ? (wdata[8] & wdata[9]) : run;
  assign start    = run_nx & ~run;
  assign key_fire = wr_clr && wdata[7:0] == KEY_FIRE && armed;
  assign restart  = start | key_fire;
  assign step     = run & tick & (stage != ST_DONE);
  assign cnt_nx   = cnt + 1'b1;

  assign int_hit = step && stage == ST_INT && cnt_nx >= span(int_code) && !restart;
  assign rst_hit = step && stage == ST_RST && cnt_nx >= span(rst_code) && !restart;
  assign early   = key_fire && run && stage == ST_INT && cnt < span(wait_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_code  <= '0;
      rst_code  <= '0;
      wait_code <= '0;
      tmr_on    <= 1'b0;
      clk_on    <= 1'b0;
    end else if (wr_ctrl) begin
      int_code  <= wdata[3:0];
      rst_code  <= wdata[7:4];
      tmr_on    <= wdata[8];
      clk_on    <= wdata[9];
      wait_code <= wdata[15:12];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
      en_q   <= '0;
    end else begin
      if (wr_lock && wdata[7:0] == KEY_LOCK) locked <= 1'b1;
      else if (wr_lock && wdata[7:0] == KEY_OPEN) locked <= 1'b0;
      if (wr_clr) armed <= (wdata[7:0] == KEY_ARM);
      if (wr_en_reg) en_q <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      stage <= ST_INT;
    end else if (restart) begin
      cnt   <= '0;
      stage <= ST_INT;
    end else if (int_hit) begin
      cnt   <= '0;
      stage <= ST_RST;
    end else if (rst_hit) begin
      stage <= ST_DONE;
    end else if (step) begin
      cnt   <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg     <= '0;
      rst_req <= 1'b0;
    end else begin
      flg[0]  <= (flg[0] & ~(wr_flg & wdata[0])) | int_hit;
      flg[1]  <= (flg[1] & ~(wr_flg & wdata[1])) | early;
      flg[2]  <= (flg[2] & ~(wr_flg & wdata[2])) | rst_hit;
      rst_req <= rst_hit & en_q[2];
    end
  end

  assign irq = |(flg & en_q);

  always_comb begin
    case (reg_idx)
      IDX_CTRL: rdata = {16'b0, wait_code, 2'b0, clk_on, tmr_on, rst_code, int_code};
      IDX_FLG:  rdata = {29'b0, flg};
      IDX_EN:   rdata = {29'b0, en_q};
      IDX_LOCK: rdata = {31'b0, locked};
      default:  rdata = '0;
    endcase
  end

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en_q[2]));

  a_r4_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flg[2]);

  a_r10_locked_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_CTRL && locked) |=> $stable(rdata[15:0]) || reg_idx != IDX_CTRL);

  a_r3_timeout_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[0]) |-> $past(tick));

  a_r2_halt_without_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));

endmodule

// File: tb/wdog_window_tb_top.sv
`timescale 1ns/1ps
module wdog_window_tb_top;
  localparam int SH = 12;
  localparam int MAXE = 31 - SH;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_req;
  int total = 0, bad = 0, pulses = 0;
  bit finished = 0;

  wdog_window #(.EXP_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  function automatic int plen(input int code);
    return 1 << (MAXE - code);
  endfunction

  function automatic logic [31:0] mk(input int ic, input int rc, input int wc, input bit on);
    return {16'b0, wc[3:0], 2'b0, on, on, rc[3:0], ic[3:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    wr_en = 1'b1; reg_idx = idx; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_idx = idx;
    #1;
    v = rdata;
  endtask

  task automatic setup(input logic [31:0] ctrl, input logic [2:0] en);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h7);
    wr(3'd3, {29'b0, en});
    wr(3'd0, ctrl);
  endtask

  task automatic key();
    wr(3'd1, 32'hA5);
    wr(3'd1, 32'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ic, rc, L, R, p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, v); chk("R1 ctrl after reset", v, 0);
    rd(3'd2, v); chk("R1 flags after reset", v, 0);
    rd(3'd5, v); chk("R1 lock after reset", v, 0);
    chk("R1 irq/rst_req after reset", {irq, rst_req}, 0);

    for (int it = 0; it < 3; it++) begin
      ic = $urandom_range(15, 13);
      L = plen(ic);
      setup(mk(ic, 12, 15, 1), 3'b001);
      repeat (L - 1) @(negedge clk);
      rd(3'd2, v); chk("R3 timeout flag before period", v[0], 0);
      chk("R9 irq before timeout", irq, 0);
      @(negedge clk);
      rd(3'd2, v); chk("R3 timeout flag at period", v[0], 1);
      chk("R9 irq with enabled timeout", irq, 1);
      wr(3'd2, 32'h0);
      rd(3'd2, v); chk("R8 writing zero keeps flag", v[0], 1);
      wr(3'd2, 32'h1);
      rd(3'd2, v); chk("R8 write one clears flag", v[0], 0);
      chk("R9 irq after clear", irq, 0);
      p0 = pulses;
      key();
      repeat (140) @(negedge clk);
      rd(3'd2, v); chk("R5 key cancels reset stage", v[2], 0);
      chk("R5 no reset pulse after key", pulses, p0);
    end

    for (int it = 0; it < 2; it++) begin
      rc = $urandom_range(15, 13);
      R = plen(rc);
      p0 = pulses;
      setup(mk(15, rc, 15, 1), 3'b100);
      repeat (16 + R - 1) @(negedge clk);
      rd(3'd2, v); chk("R4 reset flag before expiry", v[2], 0);
      chk("R4 no request before expiry", rst_req, 0);
      @(negedge clk);
      rd(3'd2, v); chk("R4 flags at reset expiry", v[2:0], 3'b101);
      chk("R4 request asserted", rst_req, 1);
      chk("R9 irq from reset flag", irq, 1);
      @(negedge clk);
      chk("R4 request is one cycle", rst_req, 0);
      repeat (60) @(negedge clk);
      chk("R4 single pulse, counter halted", pulses, p0 + 1);
    end

    p0 = pulses;
    setup(mk(15, 15, 15, 1), 3'b001);
    repeat (32) @(negedge clk);
    rd(3'd2, v); chk("R4 reset flag without request enable", v[2], 1);
    chk("R4 no pulse when enable bit 2 clear", pulses, p0);

    setup(mk(12, 12, 13, 1), 3'b010);
    repeat (5) @(negedge clk);
    key();
    rd(3'd2, v); chk("R7 early clear flagged", v[1], 1);
    chk("R9 irq from early flag", irq, 1);
    wr(3'd2, 32'h2);
    rd(3'd2, v); chk("R8 early flag cleared", v[1], 0);
    repeat (80) @(negedge clk);
    key();
    rd(3'd2, v); chk("R7 in-window clear not flagged", v[1:0], 0);
    chk("R9 irq low", irq, 0);

    L = plen(14);
    setup(mk(14, 12, 15, 1), 3'b000);
    wr(3'd1, 32'h5A);
    wr(3'd1, 32'hA5);
    wr(3'd1, 32'h33);
    wr(3'd1, 32'h5A);
    repeat (L - 1 - 4) @(negedge clk);
    rd(3'd2, v); chk("R6 broken keys: not yet timed out", v[0], 0);
    @(negedge clk);
    rd(3'd2, v); chk("R6 broken keys did not restart", v[0], 1);

    setup(mk(14, 12, 15, 1), 3'b000);
    repeat (18) @(negedge clk);
    key();
    repeat (L - 1) @(negedge clk);
    rd(3'd2, v); chk("R5 key restarted count", v[0], 0);
    @(negedge clk);
    rd(3'd2, v); chk("R5 timeout after restart", v[0], 1);

    setup(mk(15, 12, 15, 1), 3'b000);
    repeat (5) @(negedge clk);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R2 paused ticks delay timeout", v[0], 0);
    @(negedge clk);
    rd(3'd2, v); chk("R2 timeout after gated ticks", v[0], 1);

    setup(mk(15, 12, 15, 0) | 32'h100, 3'b000);
    repeat (40) @(negedge clk);
    rd(3'd2, v); chk("R2 no count without clock bit", v[0], 0);

    wr(3'd0, 32'h0);
    wr(3'd5, 32'h24);
    rd(3'd5, v); chk("R10 lock reads one", v, 1);
    wr(3'd0, mk(13, 14, 12, 0));
    rd(3'd0, v); chk("R10 locked control unchanged", v, 0);
    wr(3'd5, 32'h11);
    rd(3'd5, v); chk("R10 other value keeps lock", v, 1);
    wr(3'd5, 32'h42);
    rd(3'd5, v); chk("R10 unlock", v, 0);
    wr(3'd0, mk(13, 14, 12, 0) | 32'h200);
    rd(3'd0, v); chk("R11 control readback", v, mk(13, 14, 12, 0) | 32'h200);
    rd(3'd1, v); chk("R11 clear reads zero", v, 0);
    rd(3'd4, v); chk("R11 index 4 reads zero", v, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule